// File: doc/BRIEF.md
# Calendar Counter with Alarm

This block keeps wall-clock time and date in hardware. A single-cycle `tick` input, pulsed once per second by surrounding logic, advances a full calendar made of seconds, minutes, hours, day of month, weekday, month and year. The calendar obeys month lengths and the Gregorian leap-year rule. The year is held as an 8-bit two's-complement offset from base year 2112, so the representable span is 1984 through 2239.

Software or a controller sets the date and time through a parallel load port. The load is checked for legal field values before it is applied, and an error flag reports a rejected write. The current calendar is always visible on read-out ports.

A second register set holds an alarm date and time, written through its own port with the same legality check. A 2-bit mode selects how much of the calendar must equal the alarm. When a tick brings the calendar into agreement with the alarm, a sticky alarm flag rises. It stays high until it is cleared.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the calendar reads year offset 0x00 (2112), month 1, day 1, weekday 0, 00:00:00, and both the alarm flag and the write-error flag are low.
- R2: Each cycle with `tick` high and no load advances the seconds by one. Second 59 wraps to 0 and carries into the minute, minute 59 wraps to 0 and carries into the hour, and hour 23 wraps to 0 and advances both the day and the weekday. Weekday 6 wraps to 0. Without a tick or a load the calendar holds.
- R3: The day wraps to 1 and advances the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February. February runs to day 29 in a year divisible by 400, or divisible by 4 but not by 100 (2000 and 2112 are leap years; 2100 is not).
- R4: The year read-out is an 8-bit two's-complement offset from 2112, so 2111 reads 0xFF. After month 12, day 31 the month wraps to 1 and the offset increments modulo 256 (0xFF to 0x00, and 0x7F, 2239, to 0x80, 1984).
- R5: A legal load is applied at the next clock edge. A tick arriving in the same cycle as any load is discarded. A write with no rejected part clears the error flag.
- R6: A load is rejected when the month is outside 1..12, the day is 0 or beyond the length of that month in that year, the weekday exceeds 6, the hour exceeds 23, or the minute or second exceeds 59. A rejected load leaves the calendar unchanged and sets the error flag at the next edge.
- R7: An alarm write is checked with the same rules, except the weekday, which the alarm does not hold. A rejected alarm write sets the error flag and leaves the previous alarm in force.
- R8: `alm_mode` selects the fields compared: 0 = hour, minute and second; 1 = those plus day; 2 = those plus month; 3 = those plus year offset. The weekday is never compared.
- R9: The alarm flag sets on a tick whose advanced calendar matches the alarm under the current mode. It stays set until `alm_clr` is pulsed, and a match in the same cycle as `alm_clr` leaves the flag set. A load that makes the calendar equal to the alarm does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| ld_en | input | 1 | Load the calendar from the ld_* fields |
| ld_yofs | input | 8 | Load year offset from 2112, two's complement |
| ld_mon | input | 4 | Load month, 1..12 |
| ld_day | input | 5 | Load day of month, 1..31 |
| ld_wday | input | 3 | Load weekday, 0..6 |
| ld_hour | input | 5 | Load hour, 0..23 |
| ld_min | input | 6 | Load minute, 0..59 |
| ld_sec | input | 6 | Load second, 0..59 |
| alm_wr_en | input | 1 | Write the alarm from the alm_* fields |
| alm_yofs | input | 8 | Alarm year offset |
| alm_mon | input | 4 | Alarm month |
| alm_day | input | 5 | Alarm day of month |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| alm_mode | input | 2 | Alarm match mode |
| alm_clr | input | 1 | Clear the alarm flag |
| cur_yofs | output | 8 | Current year offset |
| cur_mon | output | 4 | Current month |
| cur_day | output | 5 | Current day of month |
| cur_wday | output | 3 | Current weekday |
| cur_hour | output | 5 | Current hour |
| cur_min | output | 6 | Current minute |
| cur_sec | output | 6 | Current second |
| alm_flag | output | 1 | Sticky alarm flag |
| wr_err | output | 1 | Last write contained a rejected part |

## Verification
The calendar registers are the read-out ports, so a wrong carry or a wrong month length shows up one cycle after the offending tick. Carries are rare, so each rollover boundary is reached by loading a time a second or two before it and comparing every field on every cycle. A wrong alarm register or comparison stays hidden until the calendar reaches the alarm time. The flag then rises one cycle late, early or never, so each match mode is exercised both with a mismatching field and with a full match.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int YOFS_W = 8;
  localparam int MON_W  = 4;
  localparam int DAY_W  = 5;
  localparam int WDAY_W = 3;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic [YOFS_W-1:0] yofs;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  typedef enum logic [MODE_W-1:0] {
    MATCH_HMS   = 2'd0,
    MATCH_DHMS  = 2'd1,
    MATCH_MDHMS = 2'd2,
    MATCH_ALL   = 2'd3
  } match_e;

  localparam cal_t CAL_RESET = '{yofs: '0, mon: 4'd1, day: 5'd1, wday: '0,
                                 hour: '0, min: '0, sec: '0};

  // Signed offset to absolute year.
  function automatic int full_year(input logic [YOFS_W-1:0] ofs, input int base);
    return base + int'($signed(ofs));
  endfunction

  function automatic logic leap_year(input int y);
    return (((y % 4) == 0) && ((y % 100) != 0)) || ((y % 400) == 0);
  endfunction

  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic fields_legal(input cal_t c, input logic use_wday, input int base);
    logic [DAY_W-1:0] lim;
    lim = month_days(c.mon, leap_year(full_year(c.yofs, base)));
    return (c.mon >= 4'd1) && (c.mon <= 4'd12) &&
           (c.day >= 5'd1) && (c.day <= lim) &&
           (c.hour < 5'd24) && (c.min < 6'd60) && (c.sec < 6'd60) &&
           (!use_wday || (c.wday < 3'd7));
  endfunction

  function automatic logic fields_match(input cal_t cur, input cal_t alm, input match_e mode);
    logic eq;
    eq = (cur.sec == alm.sec) && (cur.min == alm.min) && (cur.hour == alm.hour);
    if (mode != MATCH_HMS)                         eq = eq && (cur.day == alm.day);
    if (mode == MATCH_MDHMS || mode == MATCH_ALL)  eq = eq && (cur.mon == alm.mon);
    if (mode == MATCH_ALL)                         eq = eq && (cur.yofs == alm.yofs);
    return eq;
  endfunction

endpackage

// File: rtl/cal_check.sv
module cal_check
  import cal_pkg::*;
#(
  parameter int BASE_YEAR = 2112,
  parameter bit USE_WDAY  = 1'b1
) (
  input  cal_t val,
  output logic ok
);

  generate
    if (USE_WDAY) begin : g_with_wday
      assign ok = fields_legal(val, 1'b1, BASE_YEAR);
    end else begin : g_no_wday
      assign ok = fields_legal(val, 1'b0, BASE_YEAR);
    end
  endgenerate

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int BASE_YEAR = 2112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ld_en,
  input  logic ld_ok,
  input  cal_t ld_val,
  output cal_t cal_q,
  output cal_t cal_nxt,
  output logic step
);

  logic             sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
  logic [DAY_W-1:0] mlen;

  // A load in the same cycle swallows the tick.
  assign step = tick && !ld_en;

  always_comb begin
    mlen      = month_days(cal_q.mon, leap_year(full_year(cal_q.yofs, BASE_YEAR)));
    sec_wrap  = (cal_q.sec == 6'd59);
    min_wrap  = sec_wrap && (cal_q.min == 6'd59);
    hour_wrap = min_wrap && (cal_q.hour == 5'd23);
    day_wrap  = hour_wrap && (cal_q.day >= mlen);
    mon_wrap  = day_wrap && (cal_q.mon >= 4'd12);

    cal_nxt     = cal_q;
    cal_nxt.sec = sec_wrap ? '0 : cal_q.sec + 6'd1;
    if (sec_wrap) cal_nxt.min  = min_wrap ? '0 : cal_q.min + 6'd1;
    if (min_wrap) cal_nxt.hour = hour_wrap ? '0 : cal_q.hour + 5'd1;
    if (hour_wrap) begin
      cal_nxt.wday = (cal_q.wday >= 3'd6) ? '0 : cal_q.wday + 3'd1;
      cal_nxt.day  = day_wrap ? 5'd1 : cal_q.day + 5'd1;
    end
    if (day_wrap) cal_nxt.mon  = mon_wrap ? 4'd1 : cal_q.mon + 4'd1;
    if (mon_wrap) cal_nxt.yofs = cal_q.yofs + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= CAL_RESET;
    end else if (ld_en) begin
      if (ld_ok) cal_q <= ld_val;
    end else if (tick) begin
      cal_q <= cal_nxt;
    end
  end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic   wr_ok,
  input  cal_t   wr_val,
  input  match_e mode,
  input  logic   step,
  input  cal_t   cal_nxt,
  input  logic   clr,
  output logic   hit,
  output logic   flag
);

  cal_t alm_q;

  // Compare against the value the calendar is about to take.
  assign hit = step && fields_match(cal_nxt, alm_q, mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q <= CAL_RESET;
    end else if (wr_en && wr_ok) begin
      alm_q <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_pkg::*;
#(
  parameter int BASE_YEAR = 2112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_en,
  input  logic [YOFS_W-1:0] ld_yofs,
  input  logic [MON_W-1:0]  ld_mon,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [WDAY_W-1:0] ld_wday,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic              alm_wr_en,
  input  logic [YOFS_W-1:0] alm_yofs,
  input  logic [MON_W-1:0]  alm_mon,
  input  logic [DAY_W-1:0]  alm_day,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic [MODE_W-1:0] alm_mode,
  input  logic              alm_clr,
  output logic [YOFS_W-1:0] cur_yofs,
  output logic [MON_W-1:0]  cur_mon,
  output logic [DAY_W-1:0]  cur_day,
  output logic [WDAY_W-1:0] cur_wday,
  output logic [HOUR_W-1:0] cur_hour,
  output logic [MIN_W-1:0]  cur_min,
  output logic [SEC_W-1:0]  cur_sec,
  output logic              alm_flag,
  output logic              wr_err
);

  cal_t ld_val, alm_val, cal_q, cal_nxt;
  logic ld_ok, alm_ok, step, alm_hit;

  assign ld_val  = '{yofs: ld_yofs, mon: ld_mon, day: ld_day, wday: ld_wday,
                     hour: ld_hour, min: ld_min, sec: ld_sec};
  assign alm_val = '{yofs: alm_yofs, mon: alm_mon, day: alm_day, wday: '0,
                     hour: alm_hour, min: alm_min, sec: alm_sec};

  cal_check #(.BASE_YEAR(BASE_YEAR), .USE_WDAY(1'b1)) u_ld_chk (
    .val (ld_val),
    .ok  (ld_ok)
  );

  cal_check #(.BASE_YEAR(BASE_YEAR), .USE_WDAY(1'b0)) u_alm_chk (
    .val (alm_val),
    .ok  (alm_ok)
  );

  cal_counter #(.BASE_YEAR(BASE_YEAR)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ld_en   (ld_en),
    .ld_ok   (ld_ok),
    .ld_val  (ld_val),
    .cal_q   (cal_q),
    .cal_nxt (cal_nxt),
    .step    (step)
  );

  cal_alarm u_alm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alm_wr_en),
    .wr_ok   (alm_ok),
    .wr_val  (alm_val),
    .mode    (match_e'(alm_mode)),
    .step    (step),
    .cal_nxt (cal_nxt),
    .clr     (alm_clr),
    .hit     (alm_hit),
    .flag    (alm_flag)
  );

  // Error reflects the most recent write of either kind.
  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_err <= 1'b0;
    else if (ld_en || alm_wr_en)
      wr_err <= (ld_en && !ld_ok) || (alm_wr_en && !alm_ok);
  end

  assign cur_yofs = cal_q.yofs;
  assign cur_mon  = cal_q.mon;
  assign cur_day  = cal_q.day;
  assign cur_wday = cal_q.wday;
  assign cur_hour = cal_q.hour;
  assign cur_min  = cal_q.min;
  assign cur_sec  = cal_q.sec;

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic ld_en,
  input logic ld_ok,
  input logic alm_wr_en,
  input logic alm_clr,
  input logic alm_hit,
  input logic alm_flag,
  input logic wr_err,
  input cal_t cur
);

  p_fields_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.sec < 6'd60) && (cur.min < 6'd60) && (cur.hour < 5'd24) &&
    (cur.wday < 3'd7) && (cur.mon >= 4'd1) && (cur.mon <= 4'd12) && (cur.day >= 5'd1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_en |=> $stable(cur));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_en && (cur.sec != 6'd59) |=> cur.sec == $past(cur.sec) + 6'd1);

  p_load_clears_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && ld_ok && !alm_wr_en |=> !wr_err);

  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !ld_ok |=> $stable(cur) && wr_err);

  p_hit_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> alm_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag && !alm_clr |=> alm_flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_clr && !alm_hit |=> !alm_flag);

  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(tick && !ld_en));

endmodule

bind cal_alarm_top cal_alarm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .ld_en     (ld_en),
  .ld_ok     (ld_ok),
  .alm_wr_en (alm_wr_en),
  .alm_clr   (alm_clr),
  .alm_hit   (alm_hit),
  .alm_flag  (alm_flag),
  .wr_err    (wr_err),
  .cur       (cal_q)
);

// File: tb/cal_alarm_top_tb.sv
`timescale 1ns/1ps
module cal_alarm_top_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tick, ld_en, alm_wr_en, alm_clr;
  logic [7:0] ld_yofs, alm_yofs, cur_yofs;
  logic [3:0] ld_mon, alm_mon, cur_mon;
  logic [4:0] ld_day, alm_day, cur_day, ld_hour, alm_hour, cur_hour;
  logic [2:0] ld_wday, cur_wday;
  logic [5:0] ld_min, alm_min, cur_min, ld_sec, alm_sec, cur_sec;
  logic [1:0] alm_mode;
  logic       alm_flag, wr_err;

  cal_alarm_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en),
    .ld_yofs(ld_yofs), .ld_mon(ld_mon), .ld_day(ld_day), .ld_wday(ld_wday),
    .ld_hour(ld_hour), .ld_min(ld_min), .ld_sec(ld_sec),
    .alm_wr_en(alm_wr_en), .alm_yofs(alm_yofs), .alm_mon(alm_mon), .alm_day(alm_day),
    .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec), .alm_mode(alm_mode),
    .alm_clr(alm_clr),
    .cur_yofs(cur_yofs), .cur_mon(cur_mon), .cur_day(cur_day), .cur_wday(cur_wday),
    .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_flag(alm_flag), .wr_err(wr_err)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state (absolute years).
  int m_y, m_mo, m_d, m_wd, m_h, m_mi, m_s;
  bit m_flag, m_err;
  int a_y, a_mo, a_d, a_h, a_mi, a_s;
  int p_y, p_mo, p_d, p_wd, p_h, p_mi, p_s;
  int q_y, q_mo, q_d, q_h, q_mi, q_s;

  string       tag_q[$];
  logic [38:0] exp_q[$];
  string       mon_tag;
  logic [38:0] mon_exp, mon_act;

  function automatic int mdays(int y, int mo);
    bit lp;
    lp = (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit legal(int y, int mo, int d, int wd, int h, int mi, int s, bit usewd);
    if (mo < 1 || mo > 12) return 0;
    if (d < 1 || d > mdays(y, mo)) return 0;
    if (h > 23 || mi > 59 || s > 59) return 0;
    if (usewd && wd > 6) return 0;
    return 1;
  endfunction

  function automatic logic [38:0] pack_exp();
    logic [7:0] yo;
    yo = 8'(m_y - 2112);
    return {yo, m_mo[3:0], m_d[4:0], m_wd[2:0], m_h[4:0], m_mi[5:0], m_s[5:0], m_flag, m_err};
  endfunction

  task automatic model_step();
    bit ok1, ok2, hit;
    ok1 = 1; ok2 = 1; hit = 0;
    if (ld_en) begin
      ok1 = legal(p_y, p_mo, p_d, p_wd, p_h, p_mi, p_s, 1);
      if (ok1) begin
        m_y = p_y; m_mo = p_mo; m_d = p_d; m_wd = p_wd; m_h = p_h; m_mi = p_mi; m_s = p_s;
      end
    end else if (tick) begin
      m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_h++;
          if (m_h == 24) begin
            m_h = 0; m_wd = (m_wd + 1) % 7; m_d++;
            if (m_d > mdays(m_y, m_mo)) begin
              m_d = 1; m_mo++;
              if (m_mo == 13) begin
                m_mo = 1; m_y++;
                if (m_y == 2240) m_y = 1984;
              end
            end
          end
        end
      end
      hit = (a_s == m_s) && (a_mi == m_mi) && (a_h == m_h) &&
            (alm_mode == 2'd0 || a_d == m_d) &&
            (alm_mode < 2'd2 || a_mo == m_mo) &&
            (alm_mode != 2'd3 || a_y == m_y);
    end
    if (alm_wr_en) begin
      ok2 = legal(q_y, q_mo, q_d, 0, q_h, q_mi, q_s, 0);
      if (ok2) begin
        a_y = q_y; a_mo = q_mo; a_d = q_d; a_h = q_h; a_mi = q_mi; a_s = q_s;
      end
    end
    if (ld_en || alm_wr_en) m_err = !(ok1 && ok2);
    if (hit) m_flag = 1;
    else if (alm_clr) m_flag = 0;
  endtask

  // Driver: one clock cycle with the inputs currently set.
  task automatic cyc(string t);
    model_step();
    tag_q.push_back(t);
    exp_q.push_back(pack_exp());
    @(posedge clk);
    @(negedge clk);
    tick = 0; ld_en = 0; alm_wr_en = 0; alm_clr = 0;
  endtask

  task automatic ticks(int n, string t);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      cyc(t);
    end
  endtask

  task automatic set_ld(int y, int mo, int d, int wd, int h, int mi, int s);
    p_y = y; p_mo = mo; p_d = d; p_wd = wd; p_h = h; p_mi = mi; p_s = s;
    ld_yofs = 8'(y - 2112); ld_mon = 4'(mo); ld_day = 5'(d); ld_wday = 3'(wd);
    ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s);
    ld_en = 1;
  endtask

  task automatic set_alm(int y, int mo, int d, int h, int mi, int s);
    q_y = y; q_mo = mo; q_d = d; q_h = h; q_mi = mi; q_s = s;
    alm_yofs = 8'(y - 2112); alm_mon = 4'(mo); alm_day = 5'(d);
    alm_hour = 5'(h); alm_min = 6'(mi); alm_sec = 6'(s);
    alm_wr_en = 1;
  endtask

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // Monitor: compare every pushed expectation after its edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      mon_tag = tag_q.pop_front();
      mon_exp = exp_q.pop_front();
      mon_act = {cur_yofs, cur_mon, cur_day, cur_wday, cur_hour, cur_min, cur_sec, alm_flag, wr_err};
      n_checks++;
      if (mon_act !== mon_exp) begin
        n_fails++;
        $display("FAIL %s: got %h expected %h", mon_tag, mon_act, mon_exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; ld_en = 0; alm_wr_en = 0; alm_clr = 0; alm_mode = 2'd0;
    ld_yofs = 0; ld_mon = 0; ld_day = 0; ld_wday = 0; ld_hour = 0; ld_min = 0; ld_sec = 0;
    alm_yofs = 0; alm_mon = 0; alm_day = 0; alm_hour = 0; alm_min = 0; alm_sec = 0;
    m_y = 2112; m_mo = 1; m_d = 1; m_wd = 0; m_h = 0; m_mi = 0; m_s = 0; m_flag = 0; m_err = 0;
    a_y = 2112; a_mo = 1; a_d = 1; a_h = 0; a_mi = 0; a_s = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 month", 32'(cur_mon), 32'd1);
    chk("R1 yofs", 32'(cur_yofs), 32'h00);
    cyc("R1");

    // R2 second/minute/hour/day carries, weekday wrap, hold
    ticks(3, "R2");
    cyc("R2 hold");
    set_ld(2112, 1, 1, 5, 23, 59, 57); cyc("R5");
    ticks(4, "R2");
    set_ld(2112, 1, 9, 6, 23, 59, 58); cyc("R5");
    ticks(3, "R2");
    chk("R2 wday wrap", 32'(cur_wday), 32'd0);

    // R3 month lengths and leap years
    set_ld(2112, 2, 28, 1, 23, 59, 59); cyc("R5"); ticks(1, "R3");
    chk("R3 leap feb29", 32'(cur_day), 32'd29);
    ticks(86400 - 1, "R3");
    ticks(1, "R3");
    set_ld(2100, 2, 28, 0, 23, 59, 59); cyc("R5"); ticks(1, "R3");
    chk("R3 2100 mar", 32'(cur_mon), 32'd3);
    set_ld(2000, 2, 28, 0, 23, 59, 59); cyc("R5"); ticks(1, "R3");
    set_ld(2113, 2, 28, 0, 23, 59, 59); cyc("R5"); ticks(1, "R3");
    set_ld(2112, 4, 30, 0, 23, 59, 59); cyc("R5"); ticks(1, "R3");
    set_ld(2112, 1, 31, 0, 23, 59, 59); cyc("R5"); ticks(1, "R3");

    // R4 year offset encoding and rollover
    set_ld(2111, 12, 31, 3, 23, 59, 59); cyc("R4");
    chk("R4 2111 enc", 32'(cur_yofs), 32'hFF);
    ticks(1, "R4");
    chk("R4 wrap to base", 32'(cur_yofs), 32'h00);
    set_ld(2239, 12, 31, 3, 23, 59, 59); cyc("R4"); ticks(1, "R4");
    chk("R4 wrap 1984", 32'(cur_yofs), 32'h80);
    set_ld(2113, 12, 31, 3, 23, 59, 59); cyc("R4"); ticks(1, "R4");

    // R5 tick discarded during load
    set_ld(2120, 6, 15, 2, 12, 30, 10); tick = 1; cyc("R5 tick+load");
    chk("R5 no advance", 32'(cur_sec), 32'd10);

    // R6 illegal loads
    set_ld(2112, 0, 1, 0, 0, 0, 0);    cyc("R6 month0");
    set_ld(2112, 13, 1, 0, 0, 0, 0);   cyc("R6 month13");
    set_ld(2112, 5, 0, 0, 0, 0, 0);    cyc("R6 day0");
    set_ld(2112, 4, 31, 0, 0, 0, 0);   cyc("R6 apr31");
    set_ld(2113, 2, 29, 0, 0, 0, 0);   cyc("R6 feb29");
    set_ld(2112, 5, 5, 7, 0, 0, 0);    cyc("R6 wday7");
    set_ld(2112, 5, 5, 0, 24, 0, 0);   cyc("R6 hour24");
    set_ld(2112, 5, 5, 0, 0, 60, 0);   cyc("R6 min60");
    set_ld(2112, 5, 5, 0, 0, 0, 60);   tick = 1; cyc("R6 sec60");
    chk("R6 err", 32'(wr_err), 32'd1);
    set_ld(2112, 5, 5, 0, 0, 0, 0);    cyc("R5 err clear");

    // R8 mode 0: day/month/year ignored
    alm_mode = 2'd0;
    set_ld(2112, 3, 10, 2, 10, 0, 0); set_alm(2113, 4, 11, 10, 0, 5); cyc("R8 setup");
    ticks(5, "R8 mode0");
    chk("R8 mode0 hit", 32'(alm_flag), 32'd1);
    ticks(2, "R9 sticky");
    alm_clr = 1; cyc("R9 clear");
    // mode 1
    alm_mode = 2'd1;
    set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R8"); ticks(6, "R8 mode1 miss");
    set_alm(2113, 4, 10, 10, 0, 5); set_ld(2112, 3, 10, 4, 10, 0, 0); cyc("R8");
    ticks(6, "R8 mode1 hit");
    alm_clr = 1; cyc("R9 clear");
    // mode 2
    alm_mode = 2'd2;
    set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R8"); ticks(6, "R8 mode2 miss");
    set_alm(2113, 3, 10, 10, 0, 5); set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R8");
    ticks(6, "R8 mode2 hit");
    alm_clr = 1; cyc("R9 clear");
    // mode 3
    alm_mode = 2'd3;
    set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R8"); ticks(6, "R8 mode3 miss");
    chk("R8 mode3 year miss", 32'(alm_flag), 32'd0);
    set_alm(2112, 3, 10, 10, 0, 5); set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R8");
    ticks(6, "R8 mode3 hit");

    // R9 clear and hit in the same cycle: flag stays set
    alm_clr = 1; cyc("R9 clear");
    set_ld(2112, 3, 10, 2, 10, 0, 4); cyc("R9");
    alm_clr = 1; tick = 1; cyc("R9 clr+hit");
    chk("R9 set wins", 32'(alm_flag), 32'd1);
    alm_clr = 1; cyc("R9 clear");
    // R9 load equal to alarm does not set
    set_ld(2112, 3, 10, 2, 10, 0, 5); cyc("R9 load eq");
    cyc("R9 load eq hold");

    // R7 illegal alarm write keeps previous alarm
    set_alm(2112, 13, 10, 10, 0, 9); cyc("R7 reject");
    chk("R7 err", 32'(wr_err), 32'd1);
    set_alm(2112, 3, 0, 10, 0, 9); cyc("R7 day0");
    set_ld(2112, 3, 10, 2, 10, 0, 0); cyc("R7");
    ticks(9, "R7 old alarm");
    chk("R7 old alarm fires", 32'(alm_flag), 32'd1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule